// File: doc/BRIEF.md
# Paged Byte RAM with Window Decode

This block is an 8K-byte synchronous memory that sits on a processor bus with a 16-bit address and 8-bit data. It answers only inside a fixed window that starts at 0x8000 and spans 0x8000 to 0x9FFF. The storage is built from four 4K x 4 nibble banks. Each bank has a 12-bit address, a 4-bit data port, a write enable, a chip select and a clock.

The banks are grouped in two pairs, and each pair has two banks side by side. The bank on bits 3:0 of the bus data holds the low nibble and the bank on bits 7:4 holds the high nibble. Each pair covers one 4K page of the window. The four top address bits are decoded into one chip select per pair. Bits 11:0 of the address go unchanged to every bank. A write goes only to the pair that is selected.

A bus cycle with the write enable low and an address inside the window is a read. Its byte comes out one clock later, together with a read-valid strobe, and is taken from the pair that was selected in the cycle of the request. An access outside the window stores nothing and raises no strobe.

Top module: `paged_byte_ram`

## Requirements
- R1: After reset is released, and until the first in-window read has been clocked, busRdValid is 0 and busRdData is 0.
- R2: A byte written while busAddr is in 0x8000..0x8FFF (page 8, busAddr[15:12] = 4'b1000) is returned unchanged by a later read of the same address.
- R3: Page 9 (0x9000..0x9FFF, busAddr[15:12] = 4'b1001) uses storage separate from page 8. Addresses 0x8nnn and 0x9nnn with the same low 12 bits keep different bytes.
- R4: A read presented before rising edge N has its data and busRdValid = 1 on the outputs after edge N, for exactly one cycle. A read right after a write to the same address returns the new byte.
- R5: An address outside 0x8000..0x9FFF writes no bank, including addresses whose low 12 bits alias a stored location. Such an address gives busRdValid = 0 in the following cycle.
- R6: Whenever busRdValid is 0, busRdData is 8'h00.
- R7: The cycle after a write (busWrEn = 1), busRdValid is 0.
- R8: Back-to-back reads that alternate between the two pages each return the byte of their own page, selected by the address of the request cycle.
- R9: The window edges 0x8000, 0x8FFF, 0x9000 and 0x9FFF all store and return data. 0x7FFF and 0xA000 fall outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset of the read pipeline |
| busAddr | input | 16 | Bus byte address |
| busWrEn | input | 1 | 1 = write cycle, 0 = read cycle |
| busWrData | input | 8 | Byte to store on a write |
| busRdData | output | 8 | Returned byte, 0 when not valid |
| busRdValid | output | 1 | High one cycle after an in-window read |

## Verification
Every read result is due exactly one rising edge after the cycle that presents it. The bench drives each request just after a falling edge and compares busRdValid and busRdData at the next falling edge, which is after the edge that registered them and before the next request is clocked. A write has no output of its own. Its effect is checked by a read issued in a later cycle, which is compared one edge after that read. The reference model updates its byte array in the same step in which it predicts the write's response.

// File: rtl/paged_ram_pkg.sv
package paged_ram_pkg;
  localparam int unsigned BUS_AW   = 16;
  localparam int unsigned BUS_DW   = 8;
  localparam int unsigned BANK_AW  = 12;
  localparam int unsigned BANK_DW  = 4;
  localparam int unsigned PAIR_CNT = 2;
  localparam int unsigned LANE_CNT = BUS_DW / BANK_DW;
  localparam int unsigned PAGE_W   = BUS_AW - BANK_AW;

  // strobes from the decode control to the storage datapath
  typedef struct packed {
    logic [PAIR_CNT-1:0] cs;      // per-pair chip select, this cycle
    logic                we;      // write strobe, this cycle
    logic [PAIR_CNT-1:0] rdPick;  // one-hot pair of last cycle's read
    logic                rdOk;    // last cycle was an in-window read
  } bankCtrl_t;
endpackage

// File: rtl/ram_nibble_bank.sv
module ram_nibble_bank #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          cs,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (cs) begin
      if (we) cells[addr] <= wrData;
      else    rdData      <= cells[addr];
    end
  end
endmodule

// File: rtl/ram_decode_ctrl.sv
module ram_decode_ctrl
  import paged_ram_pkg::*;
#(
  parameter logic [BUS_AW-1:0] WIN_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] page,
  input  logic              wrEn,
  output bankCtrl_t         strobe
);
  localparam logic [PAGE_W-1:0] BASE_PAGE = WIN_BASE[BUS_AW-1 -: PAGE_W];

  logic [PAIR_CNT-1:0] pairHit;
  logic                anyHit;
  logic [PAIR_CNT-1:0] rdPickQ;
  logic                rdOkQ;

  for (genvar p = 0; p < PAIR_CNT; p++) begin : g_sel
    assign pairHit[p] = (page == BASE_PAGE + PAGE_W'(p));
  end

  assign anyHit = |pairHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPickQ <= '0;
      rdOkQ   <= 1'b0;
    end else begin
      rdOkQ   <= anyHit & ~wrEn;
      rdPickQ <= wrEn ? '0 : pairHit;
    end
  end

  always_comb begin
    strobe.cs     = pairHit;
    strobe.we     = wrEn;
    strobe.rdPick = rdPickQ;
    strobe.rdOk   = rdOkQ;
  end
endmodule

// File: rtl/ram_data_path.sv
module ram_data_path
  import paged_ram_pkg::*;
(
  input  logic               clk,
  input  bankCtrl_t          strobe,
  input  logic [BANK_AW-1:0] addr,
  input  logic [BUS_DW-1:0]  wrData,
  output logic [BUS_DW-1:0]  rdData
);
  logic [PAIR_CNT-1:0][BUS_DW-1:0] pairQ;

  for (genvar p = 0; p < PAIR_CNT; p++) begin : g_pair
    for (genvar l = 0; l < LANE_CNT; l++) begin : g_lane
      ram_nibble_bank #(
        .AW(BANK_AW),
        .DW(BANK_DW)
      ) u_bank (
        .clk   (clk),
        .cs    (strobe.cs[p]),
        .we    (strobe.we),
        .addr  (addr),
        .wrData(wrData[l*BANK_DW +: BANK_DW]),
        .rdData(pairQ[p][l*BANK_DW +: BANK_DW])
      );
    end
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < PAIR_CNT; p++) begin
      if (strobe.rdOk && strobe.rdPick[p]) rdData = rdData | pairQ[p];
    end
  end
endmodule

// File: rtl/paged_byte_ram.sv
module paged_byte_ram
  import paged_ram_pkg::*;
#(
  parameter logic [BUS_AW-1:0] WIN_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_DW-1:0] busWrData,
  output logic [BUS_DW-1:0] busRdData,
  output logic              busRdValid
);
  bankCtrl_t strobe;

  ram_decode_ctrl #(.WIN_BASE(WIN_BASE)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .page  (busAddr[BUS_AW-1 -: PAGE_W]),
    .wrEn  (busWrEn),
    .strobe(strobe)
  );

  ram_data_path u_data (
    .clk   (clk),
    .strobe(strobe),
    .addr  (busAddr[BANK_AW-1:0]),
    .wrData(busWrData),
    .rdData(busRdData)
  );

  assign busRdValid = strobe.rdOk;
endmodule

// File: rtl/paged_byte_ram_chk.sv
module paged_byte_ram_chk
  import paged_ram_pkg::*;
#(
  parameter logic [BUS_AW-1:0] WIN_BASE = 16'h8000
) (
  input logic              clk,
  input logic              rstN,
  input logic [BUS_AW-1:0] busAddr,
  input logic              busWrEn,
  input logic [BUS_DW-1:0] busRdData,
  input logic              busRdValid
);
  localparam int unsigned WIN_SPAN = PAIR_CNT * (1 << BANK_AW);
  localparam logic [BUS_AW:0] WIN_END = {1'b0, WIN_BASE} + (BUS_AW+1)'(WIN_SPAN);

  logic inWin;
  assign inWin = ({1'b0, busAddr} >= {1'b0, WIN_BASE}) && ({1'b0, busAddr} < WIN_END);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdValid |-> busRdData == '0);

  // R4
  read_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && !busWrEn) |=> busRdValid);

  // R5
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |=> !busRdValid);

  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn |=> !busRdValid);

  // R2
  reread_same_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdValid && $past(busRdValid) && ($past(busAddr, 1) == $past(busAddr, 2)))
      |-> $stable(busRdData));
endmodule

bind paged_byte_ram paged_byte_ram_chk #(.WIN_BASE(WIN_BASE)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdData (busRdData),
  .busRdValid(busRdValid)
);

// File: tb/paged_byte_ram_test.sv
module paged_byte_ram_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        busRdValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] refMem [0:8191];
  bit         known  [0:8191];

  paged_byte_ram uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .busRdValid(busRdValid)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one bus cycle: drive after the falling edge, compare at the next one
  task automatic busCycle(input logic [15:0] a, input logic we,
                          input logic [7:0] d, input string req);
    bit         hit;
    bit         expValid;
    bit         dataKnown;
    logic [7:0] expData;
    int         idx;
    hit = (a >= 16'h8000) && (a <= 16'h9FFF);
    idx = int'(a) - 32'h8000;
    expValid  = hit && !we;
    dataKnown = 1'b1;
    expData   = 8'h00;
    if (expValid) begin
      dataKnown = known[idx];
      expData   = refMem[idx];
    end
    if (hit && we) begin
      refMem[idx] = d;
      known[idx]  = 1'b1;
    end
    busAddr = a; busWrEn = we; busWrData = d;
    @(posedge clk);
    @(negedge clk);
    check(req, "valid", {7'd0, busRdValid}, {7'd0, expValid});
    if (dataKnown) check(req, "data", busRdData, expData);
  endtask

  initial begin
    int n;
    n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < 8192; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", "valid", {7'd0, busRdValid}, 8'h00);
    check("R1", "data", busRdData, 8'h00);
    busCycle(16'h0000, 1'b0, 8'h00, "R1");

    busCycle(16'h8000, 1'b1, 8'hA5, "R2");
    busCycle(16'h8FFF, 1'b1, 8'h3C, "R9");
    busCycle(16'h9000, 1'b1, 8'h5A, "R9");
    busCycle(16'h9FFF, 1'b1, 8'hC3, "R9");
    busCycle(16'h8123, 1'b1, 8'h11, "R2");
    busCycle(16'h9123, 1'b1, 8'h22, "R3");
    // R5 outside writes, some aliasing 0x123
    busCycle(16'h0123, 1'b1, 8'hEE, "R5");
    busCycle(16'hA123, 1'b1, 8'hDD, "R5");
    busCycle(16'h1123, 1'b1, 8'hCC, "R5");
    busCycle(16'h7FFF, 1'b1, 8'hBB, "R9");
    busCycle(16'hA000, 1'b1, 8'h99, "R9");
    // R7 write followed by read of idle region
    busCycle(16'h8123, 1'b0, 8'h00, "R5");
    busCycle(16'h9123, 1'b0, 8'h00, "R3");
    busCycle(16'h8000, 1'b0, 8'h00, "R2");
    busCycle(16'h8FFF, 1'b0, 8'h00, "R9");
    busCycle(16'h9000, 1'b0, 8'h00, "R9");
    busCycle(16'h9FFF, 1'b0, 8'h00, "R9");
    busCycle(16'h7FFF, 1'b0, 8'h00, "R9");
    busCycle(16'hA000, 1'b0, 8'h00, "R9");
    busCycle(16'h0123, 1'b0, 8'h00, "R6");
    // R8 alternate pages
    busCycle(16'h8123, 1'b0, 8'h00, "R8");
    busCycle(16'h9123, 1'b0, 8'h00, "R8");
    busCycle(16'h8123, 1'b0, 8'h00, "R8");
    busCycle(16'h9123, 1'b0, 8'h00, "R8");
    // R4 read right after write
    busCycle(16'h8456, 1'b1, 8'h77, "R7");
    busCycle(16'h8456, 1'b0, 8'h00, "R4");
    busCycle(16'h8456, 1'b0, 8'h00, "R4");
    busCycle(16'h9456, 1'b1, 8'h88, "R7");
    busCycle(16'h9456, 1'b0, 8'h00, "R4");
    busCycle(16'h8456, 1'b0, 8'h00, "R3");

    seed = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      logic        w;
      seed = seed * 32'd1103515245 + 32'd12345;
      a = 16'h7F00 + 16'((seed >> 8) % 32'h2200);
      w = seed[30];
      busCycle(a, w, seed[23:16], w ? "R7" : "R4");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule